// File: doc/BRIEF.md
# UART FIFO Trigger and Timeout Controller

This block holds the transmit and receive byte queues of one serial channel. It also decides when each direction needs service. Software configures it through an 8-bit control register. That register holds the queue enable, one self-clearing flush bit per direction, and an encoded fill threshold per direction.

On the transmit side, software pushes bytes and the serializer pops them. The block raises a transmit request while the queue has drained to its threshold. On the receive side, the deserializer pushes bytes and software or DMA pops them. The block raises a receive request once the queue fills to its threshold.

Bytes can be left stranded below the receive threshold on a line that has gone quiet. A small state machine counts character-time ticks from the baud logic to catch this case. After three idle character times it raises a timeout, which also drives the receive request. The timeout holds until the receive queue is drained to empty. Software uses the exposed occupancy count to learn how many bytes remain.

The idle machine has three states:
- IDLE_EMPTY: no receive data.
- IDLE_COUNT: data present, counting ticks.
- IDLE_FIRED: timeout raised.

Its transitions are:
- EMPTY to COUNT on an accepted push.
- COUNT to COUNT, clearing the tick count, on a push.
- COUNT to FIRED on the tick that completes the idle window while data is stranded.
- COUNT or FIRED to EMPTY when the queue reads empty with no push.
- FIRED to COUNT when an empty queue receives a push.
- Any state to EMPTY on a receive flush.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the register reads 0x00, both counts are 0, both empty flags are 1, tx_req is 1, and rx_req and rx_timeout are 0.
- R2: Register layout and readback. Bit 0 is the enable. Bit 1 flushes RX. Bit 2 flushes TX. Bits [5:4] are the RX threshold code. Bits [7:6] are the TX threshold code. Bits 0 and [7:4] read back as written, and bit 3 always reads 0.
- R3: Flush. A write with bit 1 (or bit 2) set makes that bit read 1 for one cycle. At the following clock edge the bit reads 0 again, and the matching queue is emptied with its overrun flag cleared; an RX flush also clears the timeout. A push or pop presented in that cycle is discarded.
- R4: Ordering and depth. Each queue returns bytes in push order, and the data output always shows the oldest byte. The count tracks occupancy up to DEPTH (64), where the full flag rises.
- R5: Overrun and underflow. A push to a full queue is dropped and sets that direction's overrun flag, which stays set until a flush. A pop of an empty queue changes nothing.
- R6: With the enable at 1, rx_req is 1 while rx_count is at or above the RX threshold: code 00 = 1, 01 = 8, 10 = 16, 11 = 32 bytes.
- R7: With the enable at 1, tx_req is 1 while tx_count is at or below the TX threshold: code 00 = 0, 01 = 16, 10 = 32, 11 = 48 bytes.
- R8: Timeout. The enable is 1 and rx_count is between 1 and threshold-1. If three char_tick pulses then arrive with no accepted RX push, rx_timeout and rx_req are 1 from the cycle after the third tick.
- R9: An accepted RX push restarts the idle tick count. rx_timeout falls in the cycle rx_count reaches 0.
- R10: With the enable at 0, each queue holds one byte. A second push is dropped with overrun. rx_req is 1 at count 1 and tx_req is 1 at count 0. The threshold codes and the timeout have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register readback |
| char_tick | input | 1 | One pulse per character time |
| tx_push | input | 1 | Push a byte into the TX queue |
| tx_data | input | 8 | TX push data |
| tx_pop | input | 1 | Pop the oldest TX byte |
| tx_q | output | 8 | Oldest TX byte |
| tx_count | output | 7 | TX occupancy |
| tx_full | output | 1 | TX queue cannot accept a push |
| tx_empty | output | 1 | TX queue empty |
| tx_ovr | output | 1 | Sticky TX overrun |
| tx_req | output | 1 | TX service request |
| rx_push | input | 1 | Push a byte into the RX queue |
| rx_data | input | 8 | RX push data |
| rx_pop | input | 1 | Pop the oldest RX byte |
| rx_q | output | 8 | Oldest RX byte |
| rx_count | output | 7 | RX occupancy |
| rx_full | output | 1 | RX queue cannot accept a push |
| rx_empty | output | 1 | RX queue empty |
| rx_ovr | output | 1 | Sticky RX overrun |
| rx_req | output | 1 | RX service request |
| rx_timeout | output | 1 | RX idle timeout raised |

## Verification
The bench uses the default DEPTH of 64 and IDLE_CHARS of 3. With these values all four codes map to the exact byte thresholds given in R6 and R7. The largest level, 48, is reached in under fifty pushes. Overrun is provoked by the 65th push. The short idle window lets a stranded-data timeout and its restart by a fresh push each be shown within a few ticks.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [1:0] {
        IDLE_EMPTY = 2'd0,
        IDLE_COUNT = 2'd1,
        IDLE_FIRED = 2'd2
    } idle_state_e;

    // Receive fill level for a 2-bit code, scaled to the queue depth.
    function automatic int unsigned rx_level(input logic [1:0] code, input int unsigned depth);
        case (code)
            2'd0:    return 1;
            2'd1:    return depth / 8;
            2'd2:    return depth / 4;
            default: return depth / 2;
        endcase
    endfunction

    // Transmit drain level for a 2-bit code, scaled to the queue depth.
    function automatic int unsigned tx_level(input logic [1:0] code, input int unsigned depth);
        case (code)
            2'd0:    return 0;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return (3 * depth) / 4;
        endcase
    endfunction

endpackage

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic [7:0] cfg_q
);
    // Bit 3 is never stored; flush bits [2:1] fall back to 0 one cycle after being set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= 8'h00;
        end else if (we) begin
            cfg_q <= {wdata[7:4], 1'b0, wdata[2:0]};
        end else begin
            cfg_q[2:1] <= 2'b00;
        end
    end
endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter  int DEPTH = 64,
    parameter  int W     = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic          flush,
    input  logic          single,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          ovr
);
    // DEPTH must be a power of two so the pointers wrap on their own.
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          ovr_q;
    logic          do_push, do_pop;

    assign full    = single ? (cnt != '0) : (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            cnt   <= '0;
            ovr_q <= 1'b0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            cnt   <= '0;
            ovr_q <= 1'b0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
            if (push && full) ovr_q <= 1'b1;
        end
    end

    assign dout  = mem[rp];
    assign count = cnt;
    assign ovr   = ovr_q;
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle
    import uart_fifo_pkg::*;
#(
    parameter  int IDLE_CHARS = 3,
    parameter  int CW         = 7,
    localparam int TW         = $clog2(IDLE_CHARS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_acc,
    input  logic          tick,
    input  logic          stranded,
    input  logic [CW-1:0] count,
    output logic          fired
);
    idle_state_e   state, nstate;
    logic [TW-1:0] ticks, nticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= IDLE_EMPTY;
            ticks <= '0;
        end else begin
            state <= nstate;
            ticks <= nticks;
        end
    end

    always_comb begin
        nstate = state;
        nticks = ticks;
        unique case (state)
            IDLE_EMPTY: begin
                nticks = '0;
                if (push_acc) nstate = IDLE_COUNT;
            end
            IDLE_COUNT: begin
                if (push_acc) begin
                    nticks = '0;
                end else if (count == '0) begin
                    nstate = IDLE_EMPTY;
                    nticks = '0;
                end else if (tick) begin
                    if (stranded && ticks >= TW'(IDLE_CHARS - 1)) begin
                        nstate = IDLE_FIRED;
                        nticks = '0;
                    end else if (ticks != TW'(IDLE_CHARS)) begin
                        nticks = ticks + TW'(1);
                    end
                end
            end
            IDLE_FIRED: begin
                nticks = '0;
                if (count == '0) nstate = push_acc ? IDLE_COUNT : IDLE_EMPTY;
            end
            default: begin
                nstate = IDLE_EMPTY;
                nticks = '0;
            end
        endcase
        if (flush) begin
            nstate = IDLE_EMPTY;
            nticks = '0;
        end
    end

    always_comb begin
        fired = (state == IDLE_FIRED);
    end
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter  int DEPTH      = 64,
    parameter  int IDLE_CHARS = 3,
    localparam int CW         = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    input  logic          char_tick,
    input  logic          tx_push,
    input  logic [7:0]    tx_data,
    input  logic          tx_pop,
    output logic [7:0]    tx_q,
    output logic [CW-1:0] tx_count,
    output logic          tx_full,
    output logic          tx_empty,
    output logic          tx_ovr,
    output logic          tx_req,
    input  logic          rx_push,
    input  logic [7:0]    rx_data,
    input  logic          rx_pop,
    output logic [7:0]    rx_q,
    output logic [CW-1:0] rx_count,
    output logic          rx_full,
    output logic          rx_empty,
    output logic          rx_ovr,
    output logic          rx_req,
    output logic          rx_timeout
);
    logic [7:0]    cfg_q;
    logic          en, rx_flush, tx_flush;
    logic [CW-1:0] rx_thr, tx_thr;
    logic          stranded, fired, rx_push_acc;

    uart_fifo_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    assign cfg_rdata = cfg_q;
    assign en        = cfg_q[0];
    assign rx_flush  = cfg_q[1];
    assign tx_flush  = cfg_q[2];
    assign rx_thr    = CW'(rx_level(cfg_q[5:4], DEPTH));
    assign tx_thr    = CW'(tx_level(cfg_q[7:6], DEPTH));

    uart_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txf (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (tx_push),
        .din    (tx_data),
        .pop    (tx_pop),
        .flush  (tx_flush),
        .single (!en),
        .dout   (tx_q),
        .count  (tx_count),
        .full   (tx_full),
        .empty  (tx_empty),
        .ovr    (tx_ovr)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxf (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (rx_push),
        .din    (rx_data),
        .pop    (rx_pop),
        .flush  (rx_flush),
        .single (!en),
        .dout   (rx_q),
        .count  (rx_count),
        .full   (rx_full),
        .empty  (rx_empty),
        .ovr    (rx_ovr)
    );

    assign rx_push_acc = rx_push && !rx_full && !rx_flush;
    assign stranded    = en && (rx_count != '0) && (rx_count < rx_thr);

    uart_rx_idle #(.IDLE_CHARS(IDLE_CHARS), .CW(CW)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (rx_flush),
        .push_acc (rx_push_acc),
        .tick     (char_tick),
        .stranded (stranded),
        .count    (rx_count),
        .fired    (fired)
    );

    assign rx_timeout = fired && en && (rx_count != '0);
    assign rx_req     = en ? ((rx_count >= rx_thr) || rx_timeout) : (rx_count != '0);
    assign tx_req     = en ? (tx_count <= tx_thr) : (tx_count == '0);
endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
    parameter  int DEPTH = 64,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [7:0]    cfg_rdata,
    input logic          rx_push,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic          rx_full,
    input logic          rx_ovr,
    input logic          tx_ovr,
    input logic          rx_req,
    input logic          tx_req,
    input logic          rx_timeout
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[3] == 1'b0);

    a_r3_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[1] && !cfg_we) |=> (rx_count == '0 && !rx_ovr && !rx_timeout && !cfg_rdata[1]));

    a_r3_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[2] && !cfg_we) |=> (tx_count == '0 && !tx_ovr && !cfg_rdata[2]));

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

    a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !cfg_rdata[1]) |=> rx_ovr);

    a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovr && !cfg_rdata[1]) |=> rx_ovr);

    a_r7_tx_empty_req: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) |-> tx_req);

    a_r8_timeout_req: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |-> (rx_req && rx_count != '0));

    a_r10_single_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[0] && rx_count != '0) |-> (rx_full && !rx_timeout));
endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_rdata  (cfg_rdata),
    .rx_push    (rx_push),
    .rx_count   (rx_count),
    .tx_count   (tx_count),
    .rx_full    (rx_full),
    .rx_ovr     (rx_ovr),
    .tx_ovr     (tx_ovr),
    .rx_req     (rx_req),
    .tx_req     (tx_req),
    .rx_timeout (rx_timeout)
);

// File: tb/uart_fifo_ctrl_test.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_test;
    localparam int DEPTH = 64;
    localparam int CW    = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = 8'h00;
    logic [7:0]    cfg_rdata;
    logic          char_tick = 1'b0;
    logic          tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0]    tx_data = 8'h00, tx_q;
    logic [CW-1:0] tx_count, rx_count;
    logic          tx_full, tx_empty, tx_ovr, tx_req;
    logic          rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0]    rx_data = 8'h00, rx_q;
    logic          rx_full, rx_empty, rx_ovr, rx_req, rx_timeout;

    always #4 clk = ~clk;

    uart_fifo_ctrl #(.DEPTH(DEPTH), .IDLE_CHARS(3)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .char_tick(char_tick),
        .tx_push(tx_push), .tx_data(tx_data), .tx_pop(tx_pop), .tx_q(tx_q),
        .tx_count(tx_count), .tx_full(tx_full), .tx_empty(tx_empty),
        .tx_ovr(tx_ovr), .tx_req(tx_req),
        .rx_push(rx_push), .rx_data(rx_data), .rx_pop(rx_pop), .rx_q(rx_q),
        .rx_count(rx_count), .rx_full(rx_full), .rx_empty(rx_empty),
        .rx_ovr(rx_ovr), .rx_req(rx_req), .rx_timeout(rx_timeout)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 0;
    int         rx_cap = DEPTH;
    int         tx_cap = DEPTH;
    logic [7:0] rxq[$];
    logic [7:0] txq[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (v[1]) rxq.delete();
        if (v[2]) txq.delete();
        rx_cap = v[0] ? DEPTH : 1;
        tx_cap = v[0] ? DEPTH : 1;
    endtask

    // Driver: push a byte and record it in the scoreboard when it fits.
    task automatic push_rx(input logic [7:0] b);
        @(negedge clk);
        rx_push = 1'b1; rx_data = b;
        if (rxq.size() < rx_cap) rxq.push_back(b);
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk);
        tx_push = 1'b1; tx_data = b;
        if (txq.size() < tx_cap) txq.push_back(b);
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    // Monitor: compare the head byte against the scoreboard as it is popped.
    task automatic pop_rx();
        @(negedge clk);
        if (rxq.size() != 0) check("R4 rx order", rx_q, rxq.pop_front());
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic pop_tx();
        @(negedge clk);
        if (txq.size() != 0) check("R4 tx order", tx_q, txq.pop_front());
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        char_tick = 1'b1;
        @(negedge clk);
        char_tick = 1'b0;
    endtask

    int rx_lv[4] = '{1, 8, 16, 32};
    int tx_lv[4] = '{0, 16, 32, 48};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cfg", cfg_rdata, 8'h00);
        check("R1 rx_count", rx_count, 0);
        check("R1 tx_count", tx_count, 0);
        check("R1 empties", {rx_empty, tx_empty}, 2'b11);
        check("R1 reqs", {tx_req, rx_req, rx_timeout}, 3'b100);

        // R2 readback, reserved bit
        cfg_wr(8'hF9);
        check("R2 readback", cfg_rdata, 8'hF1);

        // R6 receive thresholds, with R3 flush after each
        for (int e = 0; e < 4; e++) begin
            cfg_wr({2'b00, 2'(e), 4'b0001});
            for (int i = 0; i < rx_lv[e] - 1; i++) push_rx(8'(i + 16 * e));
            check("R6 rx_req below level", rx_req, 1'b0);
            push_rx(8'hA5);
            check("R6 rx_req at level", rx_req, 1'b1);
            check("R6 rx_count", rx_count, rx_lv[e]);
            cfg_wr({2'b00, 2'(e), 4'b0011});
            check("R3 rx flush bit set", cfg_rdata[1], 1'b1);
            @(negedge clk);
            check("R3 rx flush bit clear", cfg_rdata, {2'b00, 2'(e), 4'b0001});
            check("R3 rx flushed", rx_count, 0);
        end

        // R7 transmit thresholds and R4 transmit order
        for (int e = 0; e < 4; e++) begin
            cfg_wr({2'(e), 6'b000001});
            for (int i = 0; i < tx_lv[e]; i++) push_tx(8'(i * 3 + e));
            check("R7 tx_req at level", tx_req, 1'b1);
            push_tx(8'h5A);
            check("R7 tx_req above level", tx_req, 1'b0);
            while (txq.size() != 0) pop_tx();
            check("R4 tx drained", tx_count, 0);
        end

        // R5 overrun at depth, R4 order, underflow, R3 flush clears overrun
        cfg_wr(8'h01);
        for (int i = 0; i < DEPTH; i++) push_rx(8'(i ^ 8'h3C));
        check("R4 rx full count", rx_count, DEPTH);
        check("R4 rx full flag", {rx_full, rx_ovr}, 2'b10);
        push_rx(8'hEE);
        check("R5 dropped count", rx_count, DEPTH);
        check("R5 overrun set", rx_ovr, 1'b1);
        while (rxq.size() != 0) pop_rx();
        pop_rx();
        check("R5 pop on empty", rx_count, 0);
        check("R5 overrun sticky", rx_ovr, 1'b1);
        push_rx(8'h11);
        cfg_wr(8'h03);
        rx_push = 1'b1; rx_data = 8'h22;
        @(negedge clk);
        rx_push = 1'b0;
        check("R3 flush discards push", rx_count, 0);
        check("R3 flush clears overrun", rx_ovr, 1'b0);

        // R3 transmit flush
        push_tx(8'h01); push_tx(8'h02);
        cfg_wr(8'h05);
        @(negedge clk);
        check("R3 tx flushed", {tx_count, tx_req}, {7'd0, 1'b1});

        // R8 / R9 timeout with the level at 8
        cfg_wr(8'h11);
        push_rx(8'hC1); push_rx(8'hC2); push_rx(8'hC3);
        tick(); tick();
        check("R8 no early timeout", {rx_timeout, rx_req}, 2'b00);
        push_rx(8'hC4);
        tick(); tick();
        check("R9 push restarts idle", {rx_timeout, rx_req}, 2'b00);
        tick();
        check("R8 timeout raised", {rx_timeout, rx_req}, 2'b11);
        pop_rx(); pop_rx(); pop_rx();
        check("R9 timeout held", rx_timeout, 1'b1);
        pop_rx();
        check("R9 timeout clears at empty", {rx_timeout, rx_req}, 2'b00);

        // R10 disabled: one-byte holding, thresholds and timeout ignored
        cfg_wr(8'hF6);
        @(negedge clk);
        check("R10 cfg", cfg_rdata, 8'hF0);
        push_rx(8'hB1);
        check("R10 rx_req at one", {rx_req, rx_full}, 2'b11);
        push_rx(8'hB2);
        check("R10 rx second dropped", {rx_count, rx_ovr}, {7'd1, 1'b1});
        tick(); tick(); tick(); tick();
        check("R10 no timeout", {rx_timeout, rx_req}, 2'b01);
        pop_rx();
        check("R10 rx_req empty", rx_req, 1'b0);
        check("R10 tx_req empty", tx_req, 1'b1);
        push_tx(8'hD1);
        check("R10 tx_req held", {tx_req, tx_full}, 2'b01);
        push_tx(8'hD2);
        check("R10 tx second dropped", {tx_count, tx_ovr}, {7'd1, 1'b1});
        pop_tx();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule